// File: doc/BRIEF.md
# External Interrupt Redirection Controller

This block turns a set of external interrupt lines into interrupt messages for the processor cores. Every line has its own 64-bit routing entry that sets the vector, the message kind, how the destination is read, the active level of the input, edge or level sensing, and a suppress bit. Software never addresses the entries directly. It loads a register index into a select register and then reads or writes a 32-bit data window. The data window shows whichever register the select register names.

Lines that fire are held as pending. A fixed lowest-slot-first arbiter picks one pending line and copies its routing data into an output register. That register holds the message on a valid/ready port until the core side accepts it.

Level-sensed lines set an in-service flag when their message is accepted. They stay silent until an end-of-interrupt input naming their vector clears that flag.

Top module: `irqRouter`

## Requirements
- R1: After reset, every entry's low word reads 0x0001_0000, meaning only the suppress bit (bit 16) is set. Every high word and the identification register read zero, and `msgValid` is low.
- R2: A bus write at byte offset 0x00 loads an 8-bit register index, and a read at offset 0x00 returns that index in bits 7:0. Offset 0x10 reads or writes the register that the index names. Any other offset reads zero, and a write there changes nothing.
- R3: Index 0x00 is the identification register. Its 4-bit ID is bits 27:24 and is writable. All other bits read zero.
- R4: Entry s has its low word at index 0x10+2s and its high word at index 0x11+2s. The low word holds: vector in 7:0, message kind in 10:8, destination-is-logical in 11, pending status in 12, active-low in 13, in-service in 14, level in 15 and suppress in 16. The high word holds the destination in bits 31:24. Writing all-ones reads back 0x0001_AFFF in the low word and 0xFF00_0000 in the high word, because the read-only and unused bits ignore writes.
- R5: Indices that are neither the identification register nor an existing entry read zero. Writes to them change no stored state.
- R6: An unsuppressed edge-sensed line produces exactly one message per inactive-to-active transition, however long it then stays active. That message carries the entry's vector, kind, logical flag and destination.
- R7: With active-low set, a falling input is the active transition, and a rising input produces no message.
- R8: A suppressed line produces no message.
- R9: The pending status bit reads 1 from capture until the message is accepted, and then reads 0.
- R10: While `msgValid` is high and `msgReady` is low, the message fields stay stable. After an acceptance, `msgValid` is low in the next cycle.
- R11: When several lines are pending, messages leave in order of ascending slot number.
- R12: A level-sensed line sets in-service (bit 14) on acceptance and sends nothing more while it is set. An end-of-interrupt with a different vector leaves the flag set. An end-of-interrupt with its own vector clears the flag, and a still-active line then sends again.
- R13: Kinds 4, 5 and 7 are always edge-sensed, even with the level bit set, and they never set in-service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busValid | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset: 0x00 select, 0x10 window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| lineIn | input | NUM_LINES | External interrupt lines |
| eoiValid | input | 1 | End-of-interrupt strobe |
| eoiVector | input | 8 | Vector being retired |
| msgValid | output | 1 | Message available |
| msgReady | input | 1 | Core side accepts message |
| msgVector | output | 8 | Message vector |
| msgMode | output | 3 | Message kind |
| msgLogical | output | 1 | Destination is a logical mask |
| msgDest | output | 8 | Destination |

## Verification
The bench builds the controller with NUM_LINES = 4. With four lines it can sweep every slot through the full write/read-back pattern and the edge-message path, and it can raise all lines at once to see the complete arbitration order. The small index space also makes the window-decode boundaries easy to reach: the first index past the last entry, the gap below the entries, and the top of the 8-bit range. Level sensing, the forced-edge kinds and active-low inputs are each tried on chosen slots.

// File: rtl/irqRouterPkg.sv
package irqRouterPkg;
  localparam int SLOT_W = 7;  // slot field width; NUM_LINES up to 120

  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       level;
    logic       actLow;
    logic       logical;
    logic [2:0] mode;
    logic [7:0] vector;
  } entryT;

  typedef struct packed {
    logic              selAcc;   // offset 0x00 addressed
    logic              winAcc;   // offset 0x10 addressed
    logic              selWe;
    logic              winWe;
    logic              winId;
    logic              winEntry;
    logic              winHi;
    logic [SLOT_W-1:0] slot;
    logic              load;
    logic [SLOT_W-1:0] grant;
    logic              accept;
    logic [SLOT_W-1:0] held;
  } strobeT;
endpackage

// File: rtl/irqRouterCtrl.sv
module irqRouterCtrl
  import irqRouterPkg::*;
#(
  parameter int NUM_LINES = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [7:0]           busAddr,
  input  logic [7:0]           selIdx,
  input  logic [NUM_LINES-1:0] reqVec,
  input  logic                 msgReady,
  output strobeT               stb,
  output logic                 busy
);
  localparam logic [8:0] IDX_END = 9'(16 + 2 * NUM_LINES);

  logic [SLOT_W-1:0] heldSlot;
  logic [SLOT_W-1:0] grantIdx;
  logic [7:0]        relIdx;

  always_comb begin
    grantIdx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (reqVec[i]) grantIdx = SLOT_W'(i);
    end
  end

  assign relIdx = selIdx - 8'h10;

  always_comb begin
    stb          = '0;
    stb.selAcc   = (busAddr == 8'h00);
    stb.winAcc   = (busAddr == 8'h10);
    stb.selWe    = busValid & busWrite & stb.selAcc;
    stb.winWe    = busValid & busWrite & stb.winAcc;
    stb.winId    = (selIdx == 8'h00);
    stb.winEntry = (selIdx >= 8'h10) && ({1'b0, selIdx} < IDX_END);
    stb.winHi    = selIdx[0];
    stb.slot     = relIdx[SLOT_W:1];
    stb.load     = ~busy & (|reqVec);
    stb.grant    = grantIdx;
    stb.accept   = busy & msgReady;
    stb.held     = heldSlot;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      heldSlot <= '0;
    end else if (stb.accept) begin
      busy <= 1'b0;
    end else if (stb.load) begin
      busy     <= 1'b1;
      heldSlot <= grantIdx;
    end
  end
endmodule

// File: rtl/irqRouterDatapath.sv
module irqRouterDatapath
  import irqRouterPkg::*;
#(
  parameter int NUM_LINES = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobeT               stb,
  input  logic [31:0]          busWdata,
  input  logic [NUM_LINES-1:0] lineIn,
  input  logic                 eoiValid,
  input  logic [7:0]           eoiVector,
  output logic [7:0]           selIdx,
  output logic [NUM_LINES-1:0] reqVec,
  output logic [NUM_LINES-1:0] pendVec,
  output logic [NUM_LINES-1:0] rirrVec,
  output logic [NUM_LINES-1:0] maskVec,
  output logic [31:0]          busRdata,
  output logic [7:0]           msgVector,
  output logic [2:0]           msgMode,
  output logic                 msgLogical,
  output logic [7:0]           msgDest
);
  localparam int SW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic [3:0]  idReg;
  entryT       entArr [NUM_LINES];
  logic [31:0] loWord [NUM_LINES];
  logic [31:0] hiWord [NUM_LINES];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_slot
    entryT entR;
    logic  pendR, rirrR, prevAct;
    logic  act, rise, edgeMode, setCond, accHere, wrLo, wrHi;

    assign act      = lineIn[i] ^ entR.actLow;
    assign rise     = act & ~prevAct;
    assign edgeMode = ~entR.level | (entR.mode == 3'd4) | (entR.mode == 3'd5)
                      | (entR.mode == 3'd7);
    assign setCond  = ~entR.mask & (edgeMode ? rise : (act & ~rirrR));
    assign accHere  = stb.accept && (stb.held == SLOT_W'(i));
    assign wrLo     = stb.winWe && stb.winEntry && !stb.winHi && (stb.slot == SLOT_W'(i));
    assign wrHi     = stb.winWe && stb.winEntry && stb.winHi && (stb.slot == SLOT_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entR    <= '{mask: 1'b1, default: '0};
        pendR   <= 1'b0;
        rirrR   <= 1'b0;
        prevAct <= 1'b0;
      end else begin
        prevAct <= act;
        if (wrLo) begin
          entR.vector  <= busWdata[7:0];
          entR.mode    <= busWdata[10:8];
          entR.logical <= busWdata[11];
          entR.actLow  <= busWdata[13];
          entR.level   <= busWdata[15];
          entR.mask    <= busWdata[16];
        end
        if (wrHi) entR.dest <= busWdata[31:24];
        pendR <= accHere ? (edgeMode & setCond) : (pendR | setCond);
        if (accHere && !edgeMode) rirrR <= 1'b1;
        else if (eoiValid && (eoiVector == entR.vector)) rirrR <= 1'b0;
      end
    end

    assign entArr[i] = entR;
    assign pendVec[i] = pendR;
    assign rirrVec[i] = rirrR;
    assign maskVec[i] = entR.mask;
    assign reqVec[i]  = pendR & ~entR.mask;
    assign loWord[i]  = {15'b0, entR.mask, entR.level, rirrR, entR.actLow, pendR,
                         entR.logical, entR.mode, entR.vector};
    assign hiWord[i]  = {entR.dest, 24'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selIdx     <= '0;
      idReg      <= '0;
      msgVector  <= '0;
      msgMode    <= '0;
      msgLogical <= 1'b0;
      msgDest    <= '0;
    end else begin
      if (stb.selWe) selIdx <= busWdata[7:0];
      if (stb.winWe && stb.winId) idReg <= busWdata[27:24];
      if (stb.load) begin
        msgVector  <= entArr[stb.grant[SW-1:0]].vector;
        msgMode    <= entArr[stb.grant[SW-1:0]].mode;
        msgLogical <= entArr[stb.grant[SW-1:0]].logical;
        msgDest    <= entArr[stb.grant[SW-1:0]].dest;
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (stb.selAcc) busRdata = {24'b0, selIdx};
    else if (stb.winAcc) begin
      if (stb.winId) busRdata = {4'b0, idReg, 24'b0};
      else if (stb.winEntry)
        busRdata = stb.winHi ? hiWord[stb.slot[SW-1:0]] : loWord[stb.slot[SW-1:0]];
    end
  end
endmodule

// File: rtl/irqRouter.sv
module irqRouter
  import irqRouterPkg::*;
#(
  parameter int NUM_LINES = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [7:0]           busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [NUM_LINES-1:0] lineIn,
  input  logic                 eoiValid,
  input  logic [7:0]           eoiVector,
  output logic                 msgValid,
  input  logic                 msgReady,
  output logic [7:0]           msgVector,
  output logic [2:0]           msgMode,
  output logic                 msgLogical,
  output logic [7:0]           msgDest
);
  strobeT               stb;
  logic [7:0]           selIdx;
  logic [NUM_LINES-1:0] reqVec, pendVec, rirrVec, maskVec;

  irqRouterCtrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .selIdx(selIdx), .reqVec(reqVec), .msgReady(msgReady),
    .stb(stb), .busy(msgValid)
  );

  irqRouterDatapath #(.NUM_LINES(NUM_LINES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata), .lineIn(lineIn),
    .eoiValid(eoiValid), .eoiVector(eoiVector), .selIdx(selIdx), .reqVec(reqVec),
    .pendVec(pendVec), .rirrVec(rirrVec), .maskVec(maskVec), .busRdata(busRdata),
    .msgVector(msgVector), .msgMode(msgMode), .msgLogical(msgLogical), .msgDest(msgDest)
  );
endmodule

// File: rtl/irqRouterChk.sv
module irqRouterChk #(
  parameter int NUM_LINES = 24
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 msgValid,
  input logic                 msgReady,
  input logic [7:0]           msgVector,
  input logic [7:0]           msgDest,
  input logic [NUM_LINES-1:0] pendVec,
  input logic [NUM_LINES-1:0] rirrVec,
  input logic [NUM_LINES-1:0] maskVec
);
  // R10: an offered message holds still until taken
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !msgReady |=> msgValid && $stable(msgVector) && $stable(msgDest));

  // R10: acceptance retires the message for at least one cycle
  a_r10_gap_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && msgReady |=> !msgValid);

  // R8: a new message needs an unsuppressed pending slot one cycle earlier
  a_r8_source_unmasked: assert property (@(posedge clk) disable iff (!rstN)
    $rose(msgValid) |-> $past(|(pendVec & ~maskVec)));

  // R9: the offered slot's pending status stays up while offered
  a_r9_pending_while_offered: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> |pendVec);

  // R12: in-service flags only rise right after an acceptance
  a_r12_inservice_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    |(rirrVec & ~$past(rirrVec)) |-> $past(msgValid && msgReady));
endmodule

bind irqRouter irqRouterChk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgReady(msgReady),
  .msgVector(msgVector), .msgDest(msgDest), .pendVec(pendVec),
  .rirrVec(rirrVec), .maskVec(maskVec)
);

// File: tb/irqRouter_tb.sv
module irqRouter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busValid = 1'b0, busWrite = 1'b0;
  logic [7:0]    busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NL-1:0] lineIn = '0;
  logic          eoiValid = 1'b0;
  logic [7:0]    eoiVector = '0;
  logic          msgValid, msgReady = 1'b0, msgLogical;
  logic [7:0]    msgVector, msgDest;
  logic [2:0]    msgMode;

  int tests = 0, fails = 0;

  irqRouter #(.NUM_LINES(NL)) u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .lineIn(lineIn),
    .eoiValid(eoiValid), .eoiVector(eoiVector), .msgValid(msgValid),
    .msgReady(msgReady), .msgVector(msgVector), .msgMode(msgMode),
    .msgLogical(msgLogical), .msgDest(msgDest)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic busWr(logic [7:0] addr, logic [31:0] data);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = addr; busWdata = data;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic regWr(logic [7:0] idx, logic [31:0] data);
    busWr(8'h00, {24'b0, idx});
    busWr(8'h10, data);
  endtask

  task automatic regRd(logic [7:0] idx, output logic [31:0] data);
    busWr(8'h00, {24'b0, idx});
    busAddr = 8'h10;
    #1 data = busRdata;
  endtask

  function automatic logic [31:0] mkLo(logic [7:0] vec, logic [2:0] mode, logic logical,
                                       logic actLow, logic level, logic mask);
    return {15'b0, mask, level, 1'b0, actLow, 1'b0, logical, mode, vec};
  endfunction

  task automatic waitMsg(output logic got);
    got = 1'b0;
    for (int k = 0; k < 8 && !got; k++) begin
      @(negedge clk);
      got = msgValid;
    end
  endtask

  task automatic acceptMsg();
    @(negedge clk);
    msgReady = 1'b1;
    @(negedge clk);
    msgReady = 1'b0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  logic [31:0] rd;
  logic        got;

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 msgValid", {31'b0, msgValid}, 0);
    regRd(8'h00, rd); chk("R1 id", rd, 0);
    for (int s = 0; s < NL; s++) begin
      regRd(8'(16 + 2 * s), rd); chk("R1 lo", rd, 32'h0001_0000);
      regRd(8'(17 + 2 * s), rd); chk("R1 hi", rd, 0);
    end

    // R2 select readback, stray offsets
    busWr(8'h00, 32'h0000_0023);
    busAddr = 8'h00; #1 chk("R2 sel readback", busRdata, 32'h23);
    busAddr = 8'h08; #1 chk("R2 other offset read", busRdata, 0);
    busWr(8'h00, 32'h10);
    busWr(8'h04, 32'h0000_0000);
    busAddr = 8'h10; #1 chk("R2 stray write ignored", busRdata, 32'h0001_0000);

    // R3 identification
    regWr(8'h00, 32'hFFFF_FFFF);
    regRd(8'h00, rd); chk("R3 id bits", rd, 32'h0F00_0000);

    // R4 all-ones sweep per slot
    for (int s = 0; s < NL; s++) begin
      regWr(8'(16 + 2 * s), 32'hFFFF_FFFF);
      regWr(8'(17 + 2 * s), 32'hFFFF_FFFF);
      regRd(8'(16 + 2 * s), rd); chk("R4 lo ones", rd, 32'h0001_AFFF);
      regRd(8'(17 + 2 * s), rd); chk("R4 hi ones", rd, 32'hFF00_0000);
    end

    // R5 unimplemented indices
    begin
      logic [7:0] holes [4] = '{8'h01, 8'h0F, 8'(16 + 2 * NL), 8'hFF};
      for (int h = 0; h < 4; h++) begin
        regWr(holes[h], 32'hFFFF_FFFF);
        regRd(holes[h], rd); chk("R5 hole reads zero", rd, 0);
      end
    end
    regRd(8'h10, rd);   chk("R5 entry untouched", rd, 32'h0001_AFFF);
    regRd(8'h00, rd);   chk("R5 id untouched", rd, 32'h0F00_0000);
    for (int s = 0; s < NL; s++) begin
      regWr(8'(16 + 2 * s), 32'h0001_0000);
      regWr(8'(17 + 2 * s), 32'h0);
    end
    idle(2);
    chk("R8 no message from masked config", {31'b0, msgValid}, 0);

    // R6 / R9 / R10 edge sweep over every slot
    for (int s = 0; s < NL; s++) begin
      logic [2:0] md = (s == 1) ? 3'd1 : 3'd0;
      regWr(8'(17 + 2 * s), {8'(8'h50 + s), 24'b0});
      regWr(8'(16 + 2 * s), mkLo(8'(8'h30 + s), md, s[0], 1'b0, 1'b0, 1'b0));
      @(negedge clk); lineIn[s] = 1'b1;
      waitMsg(got);
      chk("R6 message raised", {31'b0, got}, 1);
      chk("R6 vector", {24'b0, msgVector}, 32'(8'h30 + s));
      chk("R6 kind", {29'b0, msgMode}, {29'b0, md});
      chk("R6 logical", {31'b0, msgLogical}, {31'b0, s[0]});
      chk("R6 dest", {24'b0, msgDest}, 32'(8'h50 + s));
      regRd(8'(16 + 2 * s), rd); chk("R9 status pending", {31'b0, rd[12]}, 1);
      chk("R10 held valid", {31'b0, msgValid}, 1);
      chk("R10 held vector", {24'b0, msgVector}, 32'(8'h30 + s));
      acceptMsg();
      chk("R10 valid drops", {31'b0, msgValid}, 0);
      regRd(8'(16 + 2 * s), rd); chk("R9 status cleared", {31'b0, rd[12]}, 0);
      idle(6);
      chk("R6 single message per edge", {31'b0, msgValid}, 0);
      lineIn[s] = 1'b0;
      idle(2);
    end

    // R11 all lines at once: ascending slot order
    @(negedge clk); lineIn = '1;
    for (int s = 0; s < NL; s++) begin
      waitMsg(got);
      chk("R11 order", {24'b0, msgVector}, 32'(8'h30 + s));
      acceptMsg();
    end
    idle(4);
    chk("R11 nothing left", {31'b0, msgValid}, 0);
    lineIn = '0;
    idle(2);

    // R8 suppressed slot 2
    regWr(8'h14, mkLo(8'h44, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1));
    @(negedge clk); lineIn[2] = 1'b1;
    waitMsg(got);
    chk("R8 masked line silent", {31'b0, got}, 0);
    lineIn[2] = 1'b0;
    idle(2);

    // R7 active-low on slot 0
    regWr(8'h10, mkLo(8'h66, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1));
    idle(2);
    regWr(8'h10, mkLo(8'h66, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0));
    @(negedge clk); lineIn[0] = 1'b1;
    waitMsg(got);
    chk("R7 rising input silent", {31'b0, got}, 0);
    lineIn[0] = 1'b0;
    waitMsg(got);
    chk("R7 falling input fires", {31'b0, got}, 1);
    chk("R7 vector", {24'b0, msgVector}, 32'h66);
    acceptMsg();
    regWr(8'h10, mkLo(8'h66, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1));
    idle(2);

    // R12 level sensing with in-service on slot 2
    regWr(8'h14, mkLo(8'h72, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
    @(negedge clk); lineIn[2] = 1'b1;
    waitMsg(got);
    chk("R12 level fires", {24'b0, msgVector}, 32'h72);
    acceptMsg();
    regRd(8'h14, rd); chk("R12 in-service set", {31'b0, rd[14]}, 1);
    idle(6);
    chk("R12 blocked while in service", {31'b0, msgValid}, 0);
    @(negedge clk); eoiValid = 1'b1; eoiVector = 8'h99;
    @(negedge clk); eoiValid = 1'b0;
    idle(4);
    regRd(8'h14, rd); chk("R12 foreign eoi ignored", {31'b0, rd[14]}, 1);
    chk("R12 still silent", {31'b0, msgValid}, 0);
    @(negedge clk); eoiValid = 1'b1; eoiVector = 8'h72;
    @(negedge clk); eoiValid = 1'b0;
    waitMsg(got);
    chk("R12 refires after eoi", {31'b0, got}, 1);
    acceptMsg();
    lineIn[2] = 1'b0;
    @(negedge clk); eoiValid = 1'b1; eoiVector = 8'h72;
    @(negedge clk); eoiValid = 1'b0;
    idle(4);
    regRd(8'h14, rd); chk("R12 cleared", {31'b0, rd[14]}, 0);
    chk("R12 inactive line silent", {31'b0, msgValid}, 0);
    regWr(8'h14, 32'h0001_0000);

    // R13 forced-edge kinds on slot 3 with level bit set
    begin
      logic [2:0] kinds [3] = '{3'd4, 3'd5, 3'd7};
      for (int k = 0; k < 3; k++) begin
        regWr(8'h16, mkLo(8'h80, kinds[k], 1'b0, 1'b0, 1'b1, 1'b0));
        @(negedge clk); lineIn[3] = 1'b1;
        waitMsg(got);
        chk("R13 fires", {31'b0, got}, 1);
        chk("R13 kind", {29'b0, msgMode}, {29'b0, kinds[k]});
        acceptMsg();
        regRd(8'h16, rd); chk("R13 no in-service", {31'b0, rd[14]}, 0);
        idle(6);
        chk("R13 edge only", {31'b0, msgValid}, 0);
        lineIn[3] = 1'b0;
        idle(2);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule